// File: doc/BRIEF.md
# Shared Rule Lookup Coprocessor

This block is a masked-match rule table that eight requesters share. Each requester has its own start strobe and search key. Each one also has a private result slot that holds a done flag, a hit flag, the index of the matching rule and an 11-bit forwarding action. A requester pulses its start line and keeps running. It later reads its done flag to learn that the answer is ready.

A round-robin arbiter serves the pending requesters one at a time. The table is a content-addressable store. Each entry holds a valid bit, a 32-bit key, a 32-bit care mask and an action word, and every entry is compared in parallel. When several entries match, the lowest-numbered one is chosen. A separate write port installs or removes rules. A table write takes precedence over the lookup in the same cycle.

Top module: `rule_cam_coproc`

## Requirements
- R1: While reset is asserted and after it is released, every requester's done, hit, index and action outputs read zero until that requester's first lookup completes.
- R2: A start pulse accepted from an idle requester clears its done flag at the next edge. With no table write in progress and no other requester waiting, done rises at the second edge after the start edge.
- R3: An entry matches a key when its valid bit is 1 and the key equals the entry key in every bit where the entry mask holds 1. Mask bits of 0 are don't-care.
- R4: When several entries match, the result reports hit=1, the smallest matching entry number as the index, and that entry's action.
- R5: When no valid entry matches, done is set with hit=0, index 0 and action 0. Entries whose valid bit is 0 never match.
- R6: A write on the update port stores the valid bit, key, mask and action at the given address. Writing valid=0 removes the rule. Every lookup that completes after the write edge sees the new contents.
- R7: No lookup completes in a cycle in which the update write strobe is high. The granted lookup completes at the first edge at which the strobe is low.
- R8: When several requesters are pending, they are served in round-robin order. The first one served is the requester after the last one served (requester 0 after reset). A grant is held until its lookup completes, and one lookup finishes every two cycles.
- R9: A start pulse from a requester whose own lookup is still pending is ignored. The first key is the one searched, and only one completion occurs.
- R10: A requester's result and done flag do not change while other requesters are served. They change only on that requester's own next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 8 | Per-requester start strobe |
| req_key | input | 256 | Per-requester 32-bit search key, requester i at bits [32i+31:32i] |
| req_done | output | 8 | Per-requester lookup-complete flag |
| req_hit | output | 8 | Per-requester match flag |
| req_idx | output | 32 | Per-requester 4-bit matching entry number |
| req_action | output | 88 | Per-requester 11-bit action word |
| upd_we | input | 1 | Rule write strobe |
| upd_addr | input | 4 | Rule entry number to write |
| upd_valid | input | 1 | Valid bit to store |
| upd_key | input | 32 | Rule key to store |
| upd_mask | input | 32 | Rule care mask to store (1 = compare bit) |
| upd_action | input | 11 | Rule action to store |

## Verification
The hardest case to reach from the ports is a lookup that has been granted but must wait because rule writes keep the table busy. That case is combined with the check that the delayed search then sees the freshly written rule. The stimulus starts a lookup whose key misses the table. In the cycle after the start edge it raises the write strobe for three cycles, installing a rule for that key. The done flag must stay low for the whole write burst and then report the new entry. A second hard case is a full eight-way collision arriving after the round-robin pointer has been moved away from requester 0. The bench reaches it by completing an ordinary single lookup first, so that the expected service order begins mid-ring.

// File: rtl/cam_coproc_pkg.sv
`timescale 1ns/1ps
package cam_coproc_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } cop_state_e;

endpackage

// File: rtl/cam_rule_table.sv
`timescale 1ns/1ps
module cam_rule_table #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  parameter int ACT_W   = 11,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [ACT_W-1:0] wr_act,
  input  logic [KEY_W-1:0] look_key,
  output logic             look_hit,
  output logic [IDX_W-1:0] look_idx,
  output logic [ACT_W-1:0] look_act
);

  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q  [ENTRIES];
  logic [KEY_W-1:0]   mask_q [ENTRIES];
  logic [ACT_W-1:0]   act_q  [ENTRIES];
  logic [ENTRIES-1:0] match_vec;

  // valid bits are the only table state that needs a reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_addr] <= wr_valid;
    end
  end

  // key, mask and action storage: clock-enabled, no reset
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_en && (wr_addr == IDX_W'(e))) begin
        key_q[e]  <= wr_key;
        mask_q[e] <= wr_mask;
        act_q[e]  <= wr_act;
      end
    end
  end

  // parallel masked compare, one comparator per entry
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = vld_q[g] && (((look_key ^ key_q[g]) & mask_q[g]) == '0);
    end
  endgenerate

  // priority select: scanning downward leaves the lowest match in place
  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    look_act = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_vec[e]) begin
        look_hit = 1'b1;
        look_idx = IDX_W'(e);
        look_act = act_q[e];
      end
    end
  end

endmodule

// File: rtl/cop_rr_arbiter.sv
`timescale 1ns/1ps
module cop_rr_arbiter #(
  parameter int N      = 8,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] sel
);

  // scan from the farthest offset down so the nearest requester to ptr wins
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int off = N - 1; off >= 0; off--) begin
      if (req[(int'(ptr) + off) % N]) begin
        any = 1'b1;
        sel = IW'((int'(ptr) + off) % N);
      end
    end
  end

endmodule

// File: rtl/cop_req_slot.sv
`timescale 1ns/1ps
module cop_req_slot #(
  parameter int KEY_W = 32,
  parameter int ACT_W = 11,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key_in,
  input  logic             finish,
  input  logic             res_hit,
  input  logic [IDX_W-1:0] res_idx,
  input  logic [ACT_W-1:0] res_act,
  output logic             pending,
  output logic [KEY_W-1:0] key_q,
  output logic             done,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic [ACT_W-1:0] act
);

  logic             pend_d, done_d, hit_d;
  logic [KEY_W-1:0] key_d;
  logic [IDX_W-1:0] idx_d;
  logic [ACT_W-1:0] act_d;
  logic             accept;

  // a start is taken only when this requester has nothing outstanding
  assign accept = start && !pending;

  always_comb begin
    pend_d = pending;
    key_d  = key_q;
    done_d = done;
    hit_d  = hit;
    idx_d  = idx;
    act_d  = act;
    if (accept) begin
      pend_d = 1'b1;
      key_d  = key_in;
      done_d = 1'b0;
    end else if (finish) begin
      pend_d = 1'b0;
      done_d = 1'b1;
      hit_d  = res_hit;
      idx_d  = res_idx;
      act_d  = res_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      key_q   <= '0;
      done    <= 1'b0;
      hit     <= 1'b0;
      idx     <= '0;
      act     <= '0;
    end else begin
      pending <= pend_d;
      key_q   <= key_d;
      done    <= done_d;
      hit     <= hit_d;
      idx     <= idx_d;
      act     <= act_d;
    end
  end

endmodule

// File: rtl/rule_cam_coproc.sv
`timescale 1ns/1ps
module rule_cam_coproc
  import cam_coproc_pkg::*;
#(
  parameter int N_REQ   = 8,
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 32,
  parameter int ACT_W   = 11,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RW     = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         req_start,
  input  logic [N_REQ*KEY_W-1:0]   req_key,
  output logic [N_REQ-1:0]         req_done,
  output logic [N_REQ-1:0]         req_hit,
  output logic [N_REQ*IDX_W-1:0]   req_idx,
  output logic [N_REQ*ACT_W-1:0]   req_action,
  input  logic                     upd_we,
  input  logic [IDX_W-1:0]         upd_addr,
  input  logic                     upd_valid,
  input  logic [KEY_W-1:0]         upd_key,
  input  logic [KEY_W-1:0]         upd_mask,
  input  logic [ACT_W-1:0]         upd_action
);

  cop_state_e       st_q, st_d;
  logic [RW-1:0]    owner_q, owner_d;
  logic [RW-1:0]    ptr_q, ptr_d;
  logic             finish;
  logic             serving;
  logic [N_REQ-1:0] slot_pend;
  logic [N_REQ-1:0] slot_fin;
  logic [KEY_W-1:0] slot_key [N_REQ];
  logic [KEY_W-1:0] look_key;
  logic             arb_any;
  logic [RW-1:0]    arb_sel;
  logic             cam_hit;
  logic [IDX_W-1:0] cam_idx;
  logic [ACT_W-1:0] cam_act;

  assign serving  = (st_q == ST_SERVE);
  assign look_key = slot_key[owner_q];

  cop_rr_arbiter #(.N(N_REQ)) u_arb (
    .req (slot_pend),
    .ptr (ptr_q),
    .any (arb_any),
    .sel (arb_sel)
  );

  cam_rule_table #(
    .ENTRIES (ENTRIES),
    .KEY_W   (KEY_W),
    .ACT_W   (ACT_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (upd_we),
    .wr_addr  (upd_addr),
    .wr_valid (upd_valid),
    .wr_key   (upd_key),
    .wr_mask  (upd_mask),
    .wr_act   (upd_action),
    .look_key (look_key),
    .look_hit (cam_hit),
    .look_idx (cam_idx),
    .look_act (cam_act)
  );

  genvar s;
  generate
    for (s = 0; s < N_REQ; s++) begin : g_slot
      assign slot_fin[s] = finish && (owner_q == RW'(s));
      cop_req_slot #(
        .KEY_W (KEY_W),
        .ACT_W (ACT_W),
        .IDX_W (IDX_W)
      ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (req_start[s]),
        .key_in  (req_key[s*KEY_W +: KEY_W]),
        .finish  (slot_fin[s]),
        .res_hit (cam_hit),
        .res_idx (cam_idx),
        .res_act (cam_act),
        .pending (slot_pend[s]),
        .key_q   (slot_key[s]),
        .done    (req_done[s]),
        .hit     (req_hit[s]),
        .idx     (req_idx[s*IDX_W +: IDX_W]),
        .act     (req_action[s*ACT_W +: ACT_W])
      );
    end
  endgenerate

  // grant in idle, search in serve; a table write postpones the search
  always_comb begin
    st_d    = st_q;
    owner_d = owner_q;
    ptr_d   = ptr_q;
    finish  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (arb_any) begin
          st_d    = ST_SERVE;
          owner_d = arb_sel;
        end
      end
      ST_SERVE: begin
        if (!upd_we) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
          ptr_d  = (owner_q == RW'(N_REQ - 1)) ? '0 : owner_q + RW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      st_q    <= st_d;
      owner_q <= owner_d;
      ptr_q   <= ptr_d;
    end
  end

endmodule

// File: rtl/cam_coproc_chk.sv
`timescale 1ns/1ps
module cam_coproc_chk #(
  parameter int N_REQ = 8,
  parameter int IDX_W = 4,
  parameter int ACT_W = 11,
  localparam int RW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   serving,
  input logic [RW-1:0]          owner,
  input logic [N_REQ-1:0]       pend,
  input logic [N_REQ-1:0]       done,
  input logic [N_REQ-1:0]       hit,
  input logic [N_REQ*IDX_W-1:0] idx,
  input logic [N_REQ*ACT_W-1:0] act,
  input logic                   upd_we
);

  // R8: the granted requester still has its lookup outstanding
  p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serving |-> pend[owner]);

  // R7: a write cycle keeps the same grant in service
  p_write_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && upd_we) |=> (serving && $stable(owner)));

  // R2: done only rises for a requester that had a pending lookup
  p_done_needs_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((done & ~$past(done) & ~$past(pend)) == '0));

  // R8: at most one lookup finishes per cycle
  p_one_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones($past(pend) & ~pend) <= 1));

  genvar i;
  generate
    for (i = 0; i < N_REQ; i++) begin : g_miss
      // R5: a miss carries a zero index and zero action
      p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done[i] && !hit[i]) |-> ((idx[i*IDX_W +: IDX_W] == '0) && (act[i*ACT_W +: ACT_W] == '0)));
    end
  endgenerate

endmodule

bind rule_cam_coproc cam_coproc_chk #(
  .N_REQ (N_REQ),
  .IDX_W (IDX_W),
  .ACT_W (ACT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .serving (serving),
  .owner   (owner_q),
  .pend    (slot_pend),
  .done    (req_done),
  .hit     (req_hit),
  .idx     (req_idx),
  .act     (req_action),
  .upd_we  (upd_we)
);

// File: tb/sim_rule_cam_coproc.sv
`timescale 1ns/1ps
module sim_rule_cam_coproc;

  localparam int N  = 8;
  localparam int E  = 16;
  localparam int KW = 32;
  localparam int AW = 11;
  localparam int IW = 4;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    st;
  logic [N*KW-1:0] kv;
  logic [N-1:0]    done, hit;
  logic [N*IW-1:0] idx;
  logic [N*AW-1:0] act;
  logic            upd_we, upd_valid;
  logic [IW-1:0]   upd_addr;
  logic [KW-1:0]   upd_key, upd_mask;
  logic [AW-1:0]   upd_action;

  rule_cam_coproc u0 (
    .clk(clk), .rst_n(rst_n), .req_start(st), .req_key(kv),
    .req_done(done), .req_hit(hit), .req_idx(idx), .req_action(act),
    .upd_we(upd_we), .upd_addr(upd_addr), .upd_valid(upd_valid),
    .upd_key(upd_key), .upd_mask(upd_mask), .upd_action(upd_action)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int last_served = N - 1;

  logic          m_vld  [E];
  logic [KW-1:0] m_key  [E];
  logic [KW-1:0] m_mask [E];
  logic [AW-1:0] m_act  [E];
  logic          e_done [N];
  logic          e_hit  [N];
  logic [IW-1:0] e_idx  [N];
  logic [AW-1:0] e_act  [N];

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] x);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, x);
    end
  endtask

  function automatic void ref_look(input logic [KW-1:0] k, output logic h,
                                   output logic [IW-1:0] ix, output logic [AW-1:0] ac);
    h = 1'b0; ix = '0; ac = '0;
    for (int e = E - 1; e >= 0; e--) begin
      if (m_vld[e] && (((k ^ m_key[e]) & m_mask[e]) == '0)) begin
        h = 1'b1; ix = IW'(e); ac = m_act[e];
      end
    end
  endfunction

  task automatic write_entry(input int a, input logic v, input logic [KW-1:0] k,
                             input logic [KW-1:0] m, input logic [AW-1:0] ac);
    @(negedge clk);
    upd_we = 1'b1; upd_addr = IW'(a); upd_valid = v;
    upd_key = k; upd_mask = m; upd_action = ac;
    @(negedge clk);
    upd_we = 1'b0;
    m_vld[a] = v; m_key[a] = k; m_mask[a] = m; m_act[a] = ac;
  endtask

  task automatic check_slots(input string req);
    for (int r = 0; r < N; r++) begin
      chk(done[r] == e_done[r], req, {31'b0, done[r]}, {31'b0, e_done[r]});
      chk(hit[r] == e_hit[r], req, {31'b0, hit[r]}, {31'b0, e_hit[r]});
      chk(idx[r*IW +: IW] == e_idx[r], req, {28'b0, idx[r*IW +: IW]}, {28'b0, e_idx[r]});
      chk(act[r*AW +: AW] == e_act[r], req, {21'b0, act[r*AW +: AW]}, {21'b0, e_act[r]});
    end
  endtask

  task automatic expect_result(input int r, input logic [KW-1:0] k, input string req);
    logic h; logic [IW-1:0] ix; logic [AW-1:0] ac;
    ref_look(k, h, ix, ac);
    e_done[r] = 1'b1; e_hit[r] = h; e_idx[r] = ix; e_act[r] = ac;
    chk(done[r] == 1'b1, req, {31'b0, done[r]}, 32'd1);
    chk(hit[r] == h, req, {31'b0, hit[r]}, {31'b0, h});
    chk(idx[r*IW +: IW] == ix, req, {28'b0, idx[r*IW +: IW]}, {28'b0, ix});
    chk(act[r*AW +: AW] == ac, req, {21'b0, act[r*AW +: AW]}, {21'b0, ac});
  endtask

  // single lookup: start edge k, grant k+1, result k+2
  task automatic lookup(input int r, input logic [KW-1:0] k, input string req);
    @(negedge clk);
    st[r] = 1'b1; kv[r*KW +: KW] = k;
    @(negedge clk);
    st = '0;
    chk(done[r] == 1'b0, "R2", {31'b0, done[r]}, 32'd0);
    @(negedge clk);
    chk(done[r] == 1'b0, "R2", {31'b0, done[r]}, 32'd0);
    @(negedge clk);
    expect_result(r, k, req);
    last_served = r;
  endtask

  initial begin
    rst_n = 1'b0; st = '0; kv = '0;
    upd_we = 1'b0; upd_addr = '0; upd_valid = 1'b0;
    upd_key = '0; upd_mask = '0; upd_action = '0;
    for (int e = 0; e < E; e++) begin
      m_vld[e] = 1'b0; m_key[e] = '0; m_mask[e] = '0; m_act[e] = '0;
    end
    for (int r = 0; r < N; r++) begin
      e_done[r] = 1'b0; e_hit[r] = 1'b0; e_idx[r] = '0; e_act[r] = '0;
    end
    repeat (3) @(negedge clk);
    check_slots("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_slots("R1");

    // rule set: entry 7 has a wide mask, entry 5 is written invalid
    for (int i = 0; i < 12; i++) begin
      write_entry(i, (i != 5), 32'hA000_0000 | (32'(i) << 4),
                  (i == 7) ? 32'hFFFF_FF80 : 32'hFFFF_FFF0, AW'(i * 37 + 5));
    end

    // R3 R4 R5: sweep keys across exact, shadowed, invalid and missing ranges
    for (int k = 0; k < 64; k++) begin
      lookup(k % N, 32'hA000_0000 | (32'(k) << 2), "R3/R4");
      check_slots("R10");
    end
    for (int j = 0; j < N; j++) begin
      lookup(j, 32'h5000_0000 + 32'(j), "R5");
    end
    check_slots("R10");

    // R7: lookup held off by a three-cycle write burst, then sees the new rule
    @(negedge clk);
    st[2] = 1'b1; kv[2*KW +: KW] = 32'h5555_0000;
    @(negedge clk);
    st = '0;
    upd_we = 1'b1; upd_addr = 4'd14; upd_valid = 1'b1;
    upd_key = 32'h5555_0000; upd_mask = 32'hFFFF_FFFF; upd_action = 11'h2AB;
    m_vld[14] = 1'b1; m_key[14] = 32'h5555_0000; m_mask[14] = 32'hFFFF_FFFF; m_act[14] = 11'h2AB;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(done[2] == 1'b0, "R7", {31'b0, done[2]}, 32'd0);
    end
    upd_we = 1'b0;
    @(negedge clk);
    expect_result(2, 32'h5555_0000, "R7");
    chk(idx[2*IW +: IW] == 4'd14, "R7", {28'b0, idx[2*IW +: IW]}, 32'd14);
    last_served = 2;

    // R6: removing entry 0 exposes the wide entry 7
    write_entry(0, 1'b0, 32'hA000_0000, 32'hFFFF_FFF0, 11'h005);
    lookup(1, 32'hA000_0000, "R6");
    chk(idx[1*IW +: IW] == 4'd7, "R6", {28'b0, idx[1*IW +: IW]}, 32'd7);

    // R9: a second start while pending is ignored
    @(negedge clk);
    st[4] = 1'b1; kv[4*KW +: KW] = 32'hA000_0010;
    @(negedge clk);
    kv[4*KW +: KW] = 32'h5000_0001;
    @(negedge clk);
    st = '0;
    @(negedge clk);
    expect_result(4, 32'hA000_0010, "R9");
    repeat (4) @(negedge clk);
    check_slots("R9");
    last_served = 4;

    // R8: all requesters start together; service begins after the last served
    @(negedge clk);
    st = '1;
    for (int r = 0; r < N; r++) begin
      kv[r*KW +: KW] = 32'hA000_0000 | (32'(r) << 4);
      e_done[r] = 1'b0;
    end
    @(negedge clk);
    st = '0;
    begin
      logic [N-1:0] acc;
      acc = '0;
      for (int j = 0; j < N; j++) begin
        repeat (2) @(negedge clk);
        acc[(last_served + 1 + j) % N] = 1'b1;
        chk(done == acc, "R8", {24'b0, done}, {24'b0, acc});
      end
    end
    for (int r = 0; r < N; r++) begin
      expect_result(r, 32'hA000_0000 | (32'(r) << 4), "R8");
    end
    check_slots("R10");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule